// File: doc/BRIEF.md
# Trace Packet Stream Decoder

This block takes a processor-trace byte stream, one byte per accepted cycle, and splits it into packets. For each complete packet it reports, in a single registered cycle, a type code, the total length in bytes, a small count field and up to eight payload bytes assembled little-endian. The payload is made from the bytes that follow the header, or follow the two-byte header for packets that begin with 0x02.

The decoder keeps a persistent packet context with three values: outside a block, inside a 4-byte block, or inside an 8-byte block. A block-begin packet sets the context. Inside a block, headers whose low two bits are zero become block items, and their length depends on the context. A header byte that cannot start a packet in the current context, or a malformed byte inside a sync run, raises a one-cycle error. Decoding then restarts with the next byte taken as a header.

Top module: `trace_pkt_decoder`

## Requirements
- R1: While reset is held and on the first cycle after release, `pkt_valid` and `pkt_err` are 0 and `blk_ctx` is 0 (none). `in_ready` is 1 from the second cycle after release.
- R2: Reporting a packet:
  - `pkt_valid` pulses exactly once per packet, in the cycle after the edge that accepts its last byte.
  - `pkt_len` is the total byte count of the packet.
  - `pkt_payload` holds the bytes after the header, with the first of them in bits 7:0. Unused bytes are zero.
  - Cycles with `in_valid` low consume nothing.
- R3: Byte 0x00 outside a block is a one-byte pad packet (type 1) with no payload.
- R4: Branch-target headers:
  - Headers whose bits 4:0 are 0x0D, 0x11, 0x01 or 0x1D give types 2, 3, 4 or 5 respectively, with count equal to header bits 7:5.
  - Bits 7:5 set the payload size: 0 gives 0 bytes, 1 gives 2, 2 gives 4, 3 or 4 gives 6, and 6 gives 8.
  - A value of 5 or 7 is an error.
- R5: Single-byte headers 0x19, 0x59 and 0x99:
  - Header 0x19 is a timestamp (type 6) with 7 payload bytes.
  - Header 0x59 is a mini time value (type 7) with 1 byte.
  - Header 0x99 takes one mode byte that is reported as the payload. Mode byte bits 7:5 = 000 gives type 8, 001 gives type 9, and any other value is an error.
- R6: After 0x02, the second byte selects the packet. Lengths include both header bytes:

  | Second byte | Packet | Type | Total length |
  |---|---|---|---|
  | 0x03 | ratio | 10 | 4 |
  | 0x23 | sync end | 11 | 2 |
  | 0x43 | paging | 12 | 8 |
  | 0x83 | stop | 13 | 2 |
  | 0xF3 | overflow | 14 | 2 |
  | 0x73 | time alignment | 15 | 7 |
  | 0xC8 | VM pointer | 16 | 7 |

  Any second byte not listed in this requirement or in R7, R8 and R10 is an error.
- R7: The pair 0x02,0x82 repeated eight times (16 bytes) is a sync packet:
  - It is type 17 with a zero payload, and it sets the context to none.
  - Any byte that breaks the pattern raises an error in the cycle after that byte.
- R8: 0x02,0x63,b is a block begin (type 18):
  - The count is b[4:0] and the payload is b.
  - The context becomes 1 (4-byte block) when b[7] is set, and 2 (8-byte block) when it is clear.
- R9: In context 1 or 2, any header with bits 1:0 = 00, including 0x00, is a block item (type 19). Its count is bits 7:3 and it carries 4 (context 1) or 8 (context 2) payload bytes.
- R10: 0x02,0x33 (type 20), 0x02,0xB3 (type 21) and overflow each set the context to 0.
- R11: Pad, ratio, timestamp, mini time and time-alignment packets never change the context. The context changes only in a cycle with `pkt_valid` high.
- R12: An unrecognised header is handled as follows:
  - `pkt_err` is high for one cycle and `pkt_valid` stays low.
  - The next accepted byte is decoded as a fresh header.
  - Outside a block this covers every even byte other than 0x00 and 0x02.
- R13: Reset discards a partial packet and clears the context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| pkt_valid | output | 1 | One-cycle packet report strobe |
| pkt_type | output | 5 | Packet type code |
| pkt_len | output | 5 | Total packet length in bytes |
| pkt_count | output | 8 | Count / sub-field |
| pkt_payload | output | 64 | Little-endian payload |
| blk_ctx | output | 2 | Packet context: 0 none, 1 4-byte block, 2 8-byte block |
| pkt_err | output | 1 | One-cycle error strobe |

## Verification
Some properties are checked on every cycle:
- Errors and packet reports never coincide.
- Every report follows an accepted byte, and its length stays in range.
- The context holds a legal value and moves only with a report.
- Timing packets leave the context unchanged, block-end, overflow and sync packets return it to none, and block items appear only inside a block.

The exact decoding of each header, the payload byte order, the lengths chosen by the context, resynchronisation after an error and the discarding of a partial packet on reset can be shown only by the bench's byte sequences and the values they are expected to produce.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int BODY_W = 5;

  typedef enum logic [4:0] {
    PK_NONE       = 5'd0,
    PK_PAD        = 5'd1,
    PK_BRANCH_TGT = 5'd2,
    PK_TRACE_ON   = 5'd3,
    PK_TRACE_OFF  = 5'd4,
    PK_FLOW_UPD   = 5'd5,
    PK_TIMESTAMP  = 5'd6,
    PK_MINI_TIME  = 5'd7,
    PK_MODE_EXEC  = 5'd8,
    PK_MODE_TXN   = 5'd9,
    PK_RATIO      = 5'd10,
    PK_SYNC_END   = 5'd11,
    PK_PAGING     = 5'd12,
    PK_STOP       = 5'd13,
    PK_OVERFLOW   = 5'd14,
    PK_TIME_ALIGN = 5'd15,
    PK_VM_PTR     = 5'd16,
    PK_SYNC       = 5'd17,
    PK_BLK_BEGIN  = 5'd18,
    PK_BLK_ITEM   = 5'd19,
    PK_BLK_END    = 5'd20,
    PK_BLK_END_IP = 5'd21
  } pk_type_e;

  typedef enum logic [1:0] {
    CX_NONE = 2'd0,
    CX_BLK4 = 2'd1,
    CX_BLK8 = 2'd2
  } ctx_e;

  typedef enum logic [1:0] {
    CL_ERR  = 2'd0,
    CL_DONE = 2'd1,
    CL_EXT  = 2'd2,
    CL_MORE = 2'd3
  } cls_kind_e;

  // Classification of one header byte: what happens next, and how many
  // body bytes follow it.
  typedef struct packed {
    cls_kind_e             kind;
    pk_type_e              ty;
    logic [7:0]            cnt;
    logic [BODY_W-1:0]     body;
  } cls_t;
endpackage

// File: rtl/tpd_hdr_class.sv
module tpd_hdr_class
  import tpd_pkg::*;
#(
  parameter int ITEM_SHORT = 4,
  parameter int ITEM_LONG  = 8
) (
  input  logic [7:0] hdr,
  input  ctx_e       ctx,
  output cls_t       cls
);
  logic [BODY_W-1:0] ip_sz;
  logic              ip_bad;
  logic              is_ip;

  always_comb begin
    ip_bad = 1'b0;
    ip_sz  = '0;
    case (hdr[7:5])
      3'd0:       ip_sz = BODY_W'(0);
      3'd1:       ip_sz = BODY_W'(2);
      3'd2:       ip_sz = BODY_W'(4);
      3'd3, 3'd4: ip_sz = BODY_W'(6);
      3'd6:       ip_sz = BODY_W'(8);
      default:    ip_bad = 1'b1;
    endcase
    is_ip = (hdr[4:0] == 5'h0D) || (hdr[4:0] == 5'h11) ||
            (hdr[4:0] == 5'h01) || (hdr[4:0] == 5'h1D);

    cls = '{kind: CL_ERR, ty: PK_NONE, cnt: 8'd0, body: '0};
    if (ctx != CX_NONE && hdr[1:0] == 2'b00) begin
      // block context: item header takes priority
      cls.kind = CL_MORE;
      cls.ty   = PK_BLK_ITEM;
      cls.cnt  = {3'b000, hdr[7:3]};
      cls.body = (ctx == CX_BLK4) ? BODY_W'(ITEM_SHORT) : BODY_W'(ITEM_LONG);
    end else if (hdr == 8'h00) begin
      cls.kind = CL_DONE;
      cls.ty   = PK_PAD;
    end else if (hdr == 8'h02) begin
      cls.kind = CL_EXT;
    end else if (hdr == 8'h19) begin
      cls.kind = CL_MORE;
      cls.ty   = PK_TIMESTAMP;
      cls.body = BODY_W'(7);
    end else if (hdr == 8'h59) begin
      cls.kind = CL_MORE;
      cls.ty   = PK_MINI_TIME;
      cls.body = BODY_W'(1);
    end else if (hdr == 8'h99) begin
      cls.kind = CL_MORE;
      cls.ty   = PK_MODE_EXEC;  // final type chosen from the mode byte
      cls.body = BODY_W'(1);
    end else if (is_ip && !ip_bad) begin
      cls.kind = (ip_sz == '0) ? CL_DONE : CL_MORE;
      cls.cnt  = {5'b00000, hdr[7:5]};
      cls.body = ip_sz;
      case (hdr[4:0])
        5'h0D:   cls.ty = PK_BRANCH_TGT;
        5'h11:   cls.ty = PK_TRACE_ON;
        5'h01:   cls.ty = PK_TRACE_OFF;
        default: cls.ty = PK_FLOW_UPD;
      endcase
    end
  end
endmodule

// File: rtl/tpd_ext_class.sv
module tpd_ext_class
  import tpd_pkg::*;
#(
  parameter int SYNC_PAIRS = 8
) (
  input  logic [7:0] sel,
  output cls_t       cls
);
  localparam int SYNC_BODY = 2 * SYNC_PAIRS - 2;

  always_comb begin
    cls = '{kind: CL_ERR, ty: PK_NONE, cnt: 8'd0, body: '0};
    case (sel)
      8'h03: begin cls.kind = CL_MORE; cls.ty = PK_RATIO;      cls.body = BODY_W'(2); end
      8'h23: begin cls.kind = CL_DONE; cls.ty = PK_SYNC_END;   end
      8'h43: begin cls.kind = CL_MORE; cls.ty = PK_PAGING;     cls.body = BODY_W'(6); end
      8'h83: begin cls.kind = CL_DONE; cls.ty = PK_STOP;       end
      8'hF3: begin cls.kind = CL_DONE; cls.ty = PK_OVERFLOW;   end
      8'h73: begin cls.kind = CL_MORE; cls.ty = PK_TIME_ALIGN; cls.body = BODY_W'(5); end
      8'hC8: begin cls.kind = CL_MORE; cls.ty = PK_VM_PTR;     cls.body = BODY_W'(5); end
      8'h82: begin cls.kind = CL_MORE; cls.ty = PK_SYNC;       cls.body = BODY_W'(SYNC_BODY); end
      8'h63: begin cls.kind = CL_MORE; cls.ty = PK_BLK_BEGIN;  cls.body = BODY_W'(1); end
      8'h33: begin cls.kind = CL_DONE; cls.ty = PK_BLK_END;    end
      8'hB3: begin cls.kind = CL_DONE; cls.ty = PK_BLK_END_IP; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tpd_payload_acc.sv
module tpd_payload_acc #(
  parameter int PAY_BYTES = 8,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             din,
  output logic [8*PAY_BYTES-1:0] acc_nx,
  output logic [8*PAY_BYTES-1:0] acc_q
);
  // one byte lane per payload position; indices past the last lane drop
  for (genvar g = 0; g < PAY_BYTES; g++) begin : g_lane
    always_comb begin
      if (clr)
        acc_nx[8*g +: 8] = 8'h00;
      else if (wr && idx == IDX_W'(g))
        acc_nx[8*g +: 8] = din;
      else
        acc_nx[8*g +: 8] = acc_q[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (clr || wr)
      acc_q <= acc_nx;
  end
endmodule

// File: rtl/trace_pkt_decoder.sv
module trace_pkt_decoder
  import tpd_pkg::*;
#(
  parameter int PAY_BYTES  = 8,
  parameter int ITEM_SHORT = 4,
  parameter int ITEM_LONG  = 8,
  parameter int SYNC_PAIRS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [7:0]             in_byte,
  output logic                   in_ready,
  output logic                   pkt_valid,
  output logic [4:0]             pkt_type,
  output logic [$clog2(2*SYNC_PAIRS+1)-1:0] pkt_len,
  output logic [7:0]             pkt_count,
  output logic [8*PAY_BYTES-1:0] pkt_payload,
  output logic [1:0]             blk_ctx,
  output logic                   pkt_err
);
  localparam int PAY_W = 8 * PAY_BYTES;
  localparam int IDX_W = $clog2(2 * SYNC_PAIRS);
  localparam int LEN_W = $clog2(2 * SYNC_PAIRS + 1);

  typedef enum logic [1:0] {S_HDR, S_EXT, S_BODY} st_e;

  st_e               st_q, st_n;
  ctx_e              ctx_q, ctx_n;
  pk_type_e          ty_q, ty_n;
  logic [7:0]        cnt_q, cnt_n;
  logic [BODY_W-1:0] rem_q, rem_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              rdy_q;

  logic              pv_q, pv_n, err_q, err_n;
  pk_type_e          oty_q, d_ty;
  logic [LEN_W-1:0]  olen_q, d_len;
  logic [7:0]        ocnt_q, d_cnt;
  logic [PAY_W-1:0]  opay_q;
  logic              done;

  logic              fire, acc_clr, acc_wr;
  logic [PAY_W-1:0]  acc_nx, acc_q;
  cls_t              hc, ec;

  tpd_hdr_class #(.ITEM_SHORT(ITEM_SHORT), .ITEM_LONG(ITEM_LONG)) u_hdr (
    .hdr(in_byte), .ctx(ctx_q), .cls(hc)
  );

  tpd_ext_class #(.SYNC_PAIRS(SYNC_PAIRS)) u_ext (
    .sel(in_byte), .cls(ec)
  );

  tpd_payload_acc #(.PAY_BYTES(PAY_BYTES), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .wr(acc_wr), .idx(idx_q),
    .din(in_byte), .acc_nx(acc_nx), .acc_q(acc_q)
  );

  assign fire = in_valid && rdy_q;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    ctx_n   = ctx_q;
    ty_n    = ty_q;
    cnt_n   = cnt_q;
    rem_n   = rem_q;
    len_n   = len_q;
    idx_n   = idx_q;
    err_n   = 1'b0;
    done    = 1'b0;
    d_ty    = ty_q;
    d_cnt   = cnt_q;
    d_len   = len_q;
    acc_clr = 1'b0;
    acc_wr  = 1'b0;

    if (fire) begin
      case (st_q)
        S_HDR: begin
          acc_clr = 1'b1;
          case (hc.kind)
            CL_ERR:  err_n = 1'b1;
            CL_DONE: begin
              done  = 1'b1;
              d_ty  = hc.ty;
              d_cnt = hc.cnt;
              d_len = LEN_W'(1);
            end
            CL_EXT: begin
              st_n  = S_EXT;
            end
            default: begin
              st_n  = S_BODY;
              ty_n  = hc.ty;
              cnt_n = hc.cnt;
              rem_n = hc.body;
              len_n = LEN_W'(1);
              idx_n = '0;
            end
          endcase
        end
        S_EXT: begin
          st_n = S_HDR;
          case (ec.kind)
            CL_DONE: begin
              done  = 1'b1;
              d_ty  = ec.ty;
              d_cnt = ec.cnt;
              d_len = LEN_W'(2);
            end
            CL_MORE: begin
              st_n  = S_BODY;
              ty_n  = ec.ty;
              cnt_n = ec.cnt;
              rem_n = ec.body;
              len_n = LEN_W'(2);
              idx_n = '0;
            end
            default: err_n = 1'b1;
          endcase
        end
        default: begin
          acc_wr = (ty_q != PK_SYNC);
          idx_n  = idx_q + 1'b1;
          len_n  = len_q + 1'b1;
          rem_n  = rem_q - 1'b1;
          if (ty_q == PK_SYNC && in_byte != (idx_q[0] ? 8'h82 : 8'h02)) begin
            err_n = 1'b1;
            st_n  = S_HDR;
          end else if (rem_q == BODY_W'(1)) begin
            st_n  = S_HDR;
            done  = 1'b1;
            d_len = len_q + 1'b1;
            if (ty_q == PK_MODE_EXEC) begin
              case (in_byte[7:5])
                3'b000:  d_ty = PK_MODE_EXEC;
                3'b001:  d_ty = PK_MODE_TXN;
                default: begin done = 1'b0; err_n = 1'b1; end
              endcase
            end else if (ty_q == PK_BLK_BEGIN) begin
              d_cnt = {3'b000, in_byte[4:0]};
            end
          end
        end
      endcase
    end

    if (done) begin
      case (d_ty)
        PK_OVERFLOW, PK_SYNC, PK_BLK_END, PK_BLK_END_IP: ctx_n = CX_NONE;
        PK_BLK_BEGIN: ctx_n = in_byte[7] ? CX_BLK4 : CX_BLK8;
        default: ;
      endcase
    end
    pv_n = done;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_HDR;
      ctx_q  <= CX_NONE;
      ty_q   <= PK_NONE;
      cnt_q  <= '0;
      rem_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      rdy_q  <= 1'b0;
      pv_q   <= 1'b0;
      err_q  <= 1'b0;
      oty_q  <= PK_NONE;
      olen_q <= '0;
      ocnt_q <= '0;
      opay_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      pv_q  <= pv_n;
      err_q <= err_n;
      if (fire) begin
        st_q  <= st_n;
        ctx_q <= ctx_n;
        ty_q  <= ty_n;
        cnt_q <= cnt_n;
        rem_q <= rem_n;
        len_q <= len_n;
        idx_q <= idx_n;
      end
      if (done) begin
        oty_q  <= d_ty;
        olen_q <= d_len;
        ocnt_q <= d_cnt;
        opay_q <= acc_nx;
      end
    end
  end

  assign in_ready    = rdy_q;
  assign pkt_valid   = pv_q;
  assign pkt_err     = err_q;
  assign pkt_type    = oty_q;
  assign pkt_len     = olen_q;
  assign pkt_count   = ocnt_q;
  assign pkt_payload = opay_q;
  assign blk_ctx     = ctx_q;
endmodule

// File: rtl/tpd_checker.sv
module tpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       pkt_valid,
  input logic [4:0] pkt_type,
  input logic [4:0] pkt_len,
  input logic [1:0] blk_ctx,
  input logic       pkt_err
);
  // R12: an error cycle never also reports a packet
  a_r12_err_excludes_report: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_err && pkt_valid));

  // R2: a report always follows an accepted byte
  a_r2_report_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(in_valid && in_ready));

  // R2: reported length is 1..16
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len >= 5'd1 && pkt_len <= 5'd16));

  // R8: context never takes the unused encoding
  a_r8_ctx_legal: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ctx != 2'd3);

  // R11: context moves only together with a report
  a_r11_ctx_moves_with_report: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_ctx) |-> pkt_valid);

  // R11: timing packets keep the context
  a_r11_timing_keeps_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (pkt_type == 5'd1 || pkt_type == 5'd6 || pkt_type == 5'd7 ||
                   pkt_type == 5'd10 || pkt_type == 5'd15)) |-> $stable(blk_ctx));

  // R10: end, overflow and sync packets leave no block open
  a_r10_end_clears_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (pkt_type == 5'd14 || pkt_type == 5'd17 ||
                   pkt_type == 5'd20 || pkt_type == 5'd21)) |-> blk_ctx == 2'd0);

  // R9: block items only inside a block
  a_r9_item_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_type == 5'd19) |-> blk_ctx != 2'd0);

  // R8: block begin opens a block
  a_r8_begin_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_type == 5'd18) |-> blk_ctx != 2'd0);
endmodule

bind trace_pkt_decoder tpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pkt_valid(pkt_valid), .pkt_type(pkt_type), .pkt_len(pkt_len),
  .blk_ctx(blk_ctx), .pkt_err(pkt_err)
);

// File: tb/trace_pkt_decoder_test.sv
module trace_pkt_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        pkt_valid;
  logic [4:0]  pkt_type;
  logic [4:0]  pkt_len;
  logic [7:0]  pkt_count;
  logic [63:0] pkt_payload;
  logic [1:0]  blk_ctx;
  logic        pkt_err;

  int total = 0;
  int bad   = 0;
  int n_rep = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  trace_pkt_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_type(pkt_type),
    .pkt_len(pkt_len), .pkt_count(pkt_count), .pkt_payload(pkt_payload),
    .blk_ctx(blk_ctx), .pkt_err(pkt_err)
  );

  always @(negedge clk) begin
    if (pkt_valid) n_rep <= n_rep + 1;
    if (pkt_err)   n_err <= n_err + 1;
  end

  typedef struct packed {
    logic [3:0]   rq;
    logic [127:0] b;    // byte k in bits 8k+7:8k
    logic [4:0]   len;
    logic [4:0]   ty;
    logic [7:0]   cnt;
    logic [63:0]  pay;
    logic [1:0]   cx;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  128'h00,                 5'd1,  5'd1,  8'h00, 64'h0, 2'd0},                 // R3
    '{4'd4,  128'h02012d,             5'd3,  5'd2,  8'h01, 64'h0201, 2'd0},              // R4
    '{4'd4,  128'h0807060504030201d1, 5'd9,  5'd3,  8'h06, 64'h0807060504030201, 2'd0},  // R4
    '{4'd4,  128'h01,                 5'd1,  5'd4,  8'h00, 64'h0, 2'd0},                 // R4
    '{4'd4,  128'h0605040302017d,     5'd7,  5'd5,  8'h03, 64'h060504030201, 2'd0},      // R4
    '{4'd4,  128'h0605040302018d,     5'd7,  5'd2,  8'h04, 64'h060504030201, 2'd0},      // R4
    '{4'd5,  128'h0706050403020119,   5'd8,  5'd6,  8'h00, 64'h07060504030201, 2'd0},    // R5
    '{4'd5,  128'h1259,               5'd2,  5'd7,  8'h00, 64'h12, 2'd0},                // R5
    '{4'd5,  128'h0199,               5'd2,  5'd8,  8'h00, 64'h01, 2'd0},                // R5
    '{4'd5,  128'h2199,               5'd2,  5'd9,  8'h00, 64'h21, 2'd0},                // R5
    '{4'd6,  128'h00120302,           5'd4,  5'd10, 8'h00, 64'h12, 2'd0},                // R6
    '{4'd6,  128'h0c0a080604024302,   5'd8,  5'd12, 8'h00, 64'h0c0a08060402, 2'd0},      // R6
    '{4'd6,  128'h01ff0002017302,     5'd7,  5'd15, 8'h00, 64'h01ff000201, 2'd0},        // R6
    '{4'd6,  128'h0504030201c802,     5'd7,  5'd16, 8'h00, 64'h0504030201, 2'd0},        // R6
    '{4'd6,  128'h2302,               5'd2,  5'd11, 8'h00, 64'h0, 2'd0},                 // R6
    '{4'd6,  128'h8302,               5'd2,  5'd13, 8'h00, 64'h0, 2'd0},                 // R6
    '{4'd8,  128'h9f6302,             5'd3,  5'd18, 8'h1f, 64'h9f, 2'd1},                // R8
    '{4'd9,  128'h04030201fc,         5'd5,  5'd19, 8'h1f, 64'h04030201, 2'd1},          // R9
    '{4'd11, 128'h00340302,           5'd4,  5'd10, 8'h00, 64'h34, 2'd1},                // R11
    '{4'd11, 128'h7759,               5'd2,  5'd7,  8'h00, 64'h77, 2'd1},                // R11
    '{4'd9,  128'ha4a3a2a100,         5'd5,  5'd19, 8'h00, 64'ha4a3a2a1, 2'd1},          // R9
    '{4'd10, 128'h3302,               5'd2,  5'd20, 8'h00, 64'h0, 2'd0},                 // R10
    '{4'd8,  128'h056302,             5'd3,  5'd18, 8'h05, 64'h05, 2'd2},                // R8
    '{4'd9,  128'h080706050403020104, 5'd9,  5'd19, 8'h00, 64'h0807060504030201, 2'd2},  // R9
    '{4'd11, 128'h0706050403020119,   5'd8,  5'd6,  8'h00, 64'h07060504030201, 2'd2},    // R11
    '{4'd10, 128'hb302,               5'd2,  5'd21, 8'h00, 64'h0, 2'd0},                 // R10
    '{4'd8,  128'h806302,             5'd3,  5'd18, 8'h00, 64'h80, 2'd1},                // R8
    '{4'd10, 128'hf302,               5'd2,  5'd14, 8'h00, 64'h0, 2'd0},                 // R10
    '{4'd8,  128'h006302,             5'd3,  5'd18, 8'h00, 64'h00, 2'd2},                // R8
    '{4'd7,  128'h82028202820282028202820282028202, 5'd16, 5'd17, 8'h00, 64'h0, 2'd0}  // R7
  };

  task automatic check(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic gap();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h02;
  endtask

  task automatic expect_pkt(input string rq, input logic [4:0] ty, input logic [4:0] len,
                            input logic [7:0] cnt, input logic [63:0] pay,
                            input logic [1:0] cx);
    logic [84:0] a, e;
    a = {pkt_valid, pkt_type, pkt_len, pkt_count, pkt_payload, blk_ctx};
    e = {1'b1, ty, len, cnt, pay, cx};
    check(a == e && !pkt_err, rq, 128'(a), 128'(e));
  endtask

  task automatic expect_err(input string rq);
    check(pkt_err && !pkt_valid, rq, 128'({pkt_err, pkt_valid}), 128'(2'b10));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  initial begin
    int base_rep;
    int base_err;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check(!pkt_valid && !pkt_err && blk_ctx == 2'd0, "R1 in reset",
          128'({pkt_valid, pkt_err, blk_ctx}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    // R1: ready after release
    check(in_ready && !pkt_valid && !pkt_err && blk_ctx == 2'd0, "R1 after release",
          128'({in_ready, pkt_valid, pkt_err, blk_ctx}), 128'(5'b10000));

    // table walk
    base_rep = n_rep;
    base_err = n_err;
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i].len); k++) put(VEC[i].b[8*k +: 8]);
      gap();
      expect_pkt($sformatf("R%0d vec %0d", VEC[i].rq, i), VEC[i].ty, VEC[i].len,
                 VEC[i].cnt, VEC[i].pay, VEC[i].cx);
    end
    @(negedge clk);
    // R2: exactly one report per packet, no errors
    check(n_rep - base_rep == NV && n_err == base_err, "R2 one report per packet",
          128'(n_rep - base_rep), 128'(NV));

    // R12: even byte outside a block, then resync on pad
    put(8'h04); gap();
    expect_err("R12 bad header");
    gap();
    check(!pkt_err, "R12 error is one cycle", 128'(pkt_err), 128'(0));
    put(8'h00); gap();
    expect_pkt("R12 resync pad", 5'd1, 5'd1, 8'h00, 64'h0, 2'd0);

    // R4: size code 5 is illegal
    put(8'had); gap();
    expect_err("R4 size code 5");

    // R6: unknown extended selector, then resync
    put(8'h02); put(8'h55); gap();
    expect_err("R6 bad selector");
    put(8'h00); gap();
    expect_pkt("R6 resync pad", 5'd1, 5'd1, 8'h00, 64'h0, 2'd0);

    // R5: illegal mode byte
    put(8'h99); put(8'h40); gap();
    expect_err("R5 bad mode");

    // R7: broken sync run flagged at the breaking byte
    put(8'h02); put(8'h82); put(8'h02); put(8'h83); gap();
    expect_err("R7 broken sync");
    put(8'h00); gap();
    expect_pkt("R7 resync pad", 5'd1, 5'd1, 8'h00, 64'h0, 2'd0);

    // R2: idle cycles inside a packet consume nothing
    put(8'h2d); gap(); gap(); gap();
    check(!pkt_valid && !pkt_err, "R2 no report during gap",
          128'({pkt_valid, pkt_err}), 128'(0));
    put(8'hab); put(8'hcd); gap();
    expect_pkt("R2 gapped packet", 5'd2, 5'd3, 8'h01, 64'hcdab, 2'd0);

    // R13: reset mid-packet inside a block
    put(8'h02); put(8'h63); put(8'h9f); gap();
    expect_pkt("R13 open block", 5'd18, 5'd3, 8'h1f, 64'h9f, 2'd1);
    put(8'h19); put(8'h01); put(8'h02); gap();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(blk_ctx == 2'd0 && !pkt_valid, "R13 reset clears ctx",
          128'({blk_ctx, pkt_valid}), 128'(0));
    put(8'h00); gap();
    expect_pkt("R13 fresh header after reset", 5'd1, 5'd1, 8'h00, 64'h0, 2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule